// File: doc/BRIEF.md
# Clock Output Power-Management Controller

This block is the control logic of a two-pair differential clock generator. It watches an asynchronous power-good / power-down input and, on the first time that input goes high after device reset, captures two board straps. One strap picks the 7-bit bus address the device answers to. The other is a three-level strap, presented here as a decoded 2-bit code, that picks the spread-spectrum depth. Both captured values hold until the next device reset.

After start-up the block decides, every cycle, whether each differential pair runs or has both lines driven low. A pair runs only while all of these hold: power-good is high, the PLL reports lock, the pair's active-low enable pin is low, and the pair's enable register bit is 1. The block also drives the state of the single-ended reference output. That output is high-impedance until the first power-good assertion. After that it is driven low during power-down and runs otherwise. The power-good input and the enable pins pass through a two-flop synchroniser before they are used. The PLL lock flag is taken as already synchronous to the control clock.

Top module: `clkout_pm_ctrl`

## Requirements
- R1: After reset, both enable register bits are 1 and `ref_hiz` is 1. `pair_run` is all 0 and `pair_drive_low` is all 1. `bus_addr` is 7'b1101000 and `ss_mode` is 2'b00.
- R2: At the first synchronised power-good rise, the address strap is captured. 0 gives `bus_addr` 7'b1101000 and 1 gives 7'b1101010.
- R3: At the same event, the spread strap code is captured. Input 2'b00 (low) gives `ss_mode` 2'b00 (spread off). Input 2'b01 (mid) gives 2'b01 (-0.25%). Input 2'b10 (high) gives 2'b10 (-0.5%). Input 2'b11 is not a legal level and gives 2'b00. `ss_mode` is never 2'b11.
- R4: Once captured, `bus_addr` and `ss_mode` ignore changes on the strap inputs and ignore later power-down cycles, until device reset.
- R5: While the synchronised power-good is low, every pair has `pair_run`=0 and `pair_drive_low`=1.
- R6: Bit i of `pair_run` is 1 exactly when the block has started, power-good is high, `pll_lock` is 1, `oe_n_in[i]` is 0 and enable register bit i is 1. `pair_drive_low` is always the inverse of `pair_run`.
- R7: A cycle with `oe_wr`=1 loads `oe_wdata` into the enable register. A 0 bit stops that pair and a 1 bit lets it run.
- R8: `ref_hiz` is 1 from reset until the first power-good rise. After that it stays 0 until reset. `ref_drive_low` is 1 when started and power-good is low, and 0 otherwise.
- R9: While `pll_lock` is 0, no pair runs.
- R10: `pwrgd_in` and `oe_n_in` pass through two flops. `ref_hiz` falls after the third rising clock edge that follows `pwrgd_in` going high, and is still 1 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high device reset |
| pwrgd_in | input | 1 | Asynchronous power-good / power-down input |
| oe_n_in | input | 2 | Asynchronous active-low per-pair enable pins |
| pll_lock | input | 1 | PLL lock flag, synchronous to clk |
| strap_addr_sel | input | 1 | Address-select strap |
| strap_ss_lvl | input | 2 | Decoded three-level spread strap (00 low, 01 mid, 10 high) |
| oe_wr | input | 1 | Enable register write strobe |
| oe_wdata | input | 2 | Enable register write data, one bit per pair |
| bus_addr | output | 7 | Resolved 7-bit bus address |
| ss_mode | output | 2 | Spread mode: 00 off, 01 -0.25%, 10 -0.5% |
| pair_run | output | 2 | Per-pair run gate |
| pair_drive_low | output | 2 | Per-pair drive true and complement low |
| ref_hiz | output | 1 | Reference output high-impedance |
| ref_drive_low | output | 1 | Reference output driven low |

## Verification
Two functions can fall in the same cycle: the strap capture at the first power-good rise, and the pair gating driven by lock, the pins and the register. Power-good is raised while lock and the pins are already enabled, so the pairs begin running in the very cycle the straps are captured. The bench checks that the captured address and spread code match that rise and not later strap values. Random mixes of power-good, lock, pins and register writes are then compared against a bench model of the run condition. Strap changes made during later power cycles are checked to have no effect.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] ADDR_BASE = 7'b1101000;
    localparam int ADDR_SEL_BIT = 1;

    typedef enum logic [1:0] {
        SS_OFF       = 2'b00,
        SS_DOWN_QTR  = 2'b01,
        SS_DOWN_HALF = 2'b10
    } ss_mode_e;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } tri_lvl_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        ss_mode_e          ss;
    } strap_cfg_t;

    function automatic logic [ADDR_W-1:0] addr_from_strap(input logic sel);
        logic [ADDR_W-1:0] a;
        a = ADDR_BASE;
        a[ADDR_SEL_BIT] = sel;
        return a;
    endfunction

    function automatic ss_mode_e ss_from_level(input logic [1:0] lvl);
        case (lvl)
            LVL_MID:  return SS_DOWN_QTR;
            LVL_HIGH: return SS_DOWN_HALF;
            default:  return SS_OFF;
        endcase
    endfunction

    function automatic strap_cfg_t cfg_default();
        strap_cfg_t c;
        c.addr = ADDR_BASE;
        c.ss   = SS_OFF;
        return c;
    endfunction

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkpm_strap_latch.sv
module clkpm_strap_latch
    import clkpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pg_sync,
    input  logic       addr_sel,
    input  logic [1:0] ss_level,
    output logic       started,
    output strap_cfg_t cfg
);
    logic first_rise;

    assign first_rise = pg_sync && !started;

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
            cfg     <= cfg_default();
        end else if (first_rise) begin
            started  <= 1'b1;
            cfg.addr <= addr_from_strap(addr_sel);
            cfg.ss   <= ss_from_level(ss_level);
        end
    end
endmodule

// File: rtl/clkpm_pair_gate.sv
module clkpm_pair_gate #(
    parameter int NUM_PAIRS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 oe_wr,
    input  logic [NUM_PAIRS-1:0] oe_wdata,
    input  logic                 started,
    input  logic                 pg_sync,
    input  logic                 pll_lock,
    input  logic [NUM_PAIRS-1:0] oe_n_sync,
    output logic [NUM_PAIRS-1:0] run,
    output logic [NUM_PAIRS-1:0] drive_low
);
    logic [NUM_PAIRS-1:0] oe_bits;
    logic                 global_ok;

    assign global_ok = started && pg_sync && pll_lock;

    generate
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
            always_ff @(posedge clk) begin
                if (rst)        oe_bits[i] <= 1'b1;
                else if (oe_wr) oe_bits[i] <= oe_wdata[i];
            end

            always_comb begin
                run[i]       = global_ok && !oe_n_sync[i] && oe_bits[i];
                drive_low[i] = !run[i];
            end
        end
    endgenerate
endmodule

// File: rtl/clkout_pm_ctrl.sv
module clkout_pm_ctrl
    import clkpm_pkg::*;
#(
    parameter int NUM_PAIRS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwrgd_in,
    input  logic [NUM_PAIRS-1:0] oe_n_in,
    input  logic                 pll_lock,
    input  logic                 strap_addr_sel,
    input  logic [1:0]           strap_ss_lvl,
    input  logic                 oe_wr,
    input  logic [NUM_PAIRS-1:0] oe_wdata,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [1:0]           ss_mode,
    output logic [NUM_PAIRS-1:0] pair_run,
    output logic [NUM_PAIRS-1:0] pair_drive_low,
    output logic                 ref_hiz,
    output logic                 ref_drive_low
);
    localparam int SYNC_W = NUM_PAIRS + 1;

    logic [SYNC_W-1:0]    sync_in;
    logic [SYNC_W-1:0]    sync_out;
    logic                 pg_sync;
    logic [NUM_PAIRS-1:0] oe_n_sync;
    logic                 started;
    strap_cfg_t           cfg;

    assign sync_in   = {oe_n_in, pwrgd_in};
    assign pg_sync   = sync_out[0];
    assign oe_n_sync = sync_out[SYNC_W-1:1];

    clkpm_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_out)
    );

    clkpm_strap_latch u_strap (
        .clk      (clk),
        .rst      (rst),
        .pg_sync  (pg_sync),
        .addr_sel (strap_addr_sel),
        .ss_level (strap_ss_lvl),
        .started  (started),
        .cfg      (cfg)
    );

    clkpm_pair_gate #(.NUM_PAIRS(NUM_PAIRS)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .oe_wr     (oe_wr),
        .oe_wdata  (oe_wdata),
        .started   (started),
        .pg_sync   (pg_sync),
        .pll_lock  (pll_lock),
        .oe_n_sync (oe_n_sync),
        .run       (pair_run),
        .drive_low (pair_drive_low)
    );

    always_comb begin
        bus_addr      = cfg.addr;
        ss_mode       = cfg.ss;
        ref_hiz       = !started;
        ref_drive_low = started && !pg_sync;
    end
endmodule

// File: rtl/clkpm_chk.sv
module clkpm_chk #(
    parameter int NUM_PAIRS = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pwrgd_in,
    input logic                 pll_lock,
    input logic [6:0]           bus_addr,
    input logic [1:0]           ss_mode,
    input logic [NUM_PAIRS-1:0] pair_run,
    input logic [NUM_PAIRS-1:0] pair_drive_low,
    input logic                 ref_hiz,
    input logic                 ref_drive_low
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (ref_hiz && pair_run == '0));

    assert_ss_legal_R3: assert property (@(posedge clk) disable iff (rst)
        ss_mode != 2'b11);

    assert_straps_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ref_hiz |=> ($stable(bus_addr) && $stable(ss_mode)));

    assert_pd_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(pwrgd_in, 2) && !$past(pwrgd_in)) |-> pair_run == '0);

    assert_complement_R6: assert property (@(posedge clk) disable iff (rst)
        (pair_run & pair_drive_low) == '0 && (pair_run | pair_drive_low) == '1);

    assert_ref_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !ref_hiz |=> !ref_hiz);

    assert_hiz_no_run_R8: assert property (@(posedge clk) disable iff (rst)
        ref_hiz |-> (pair_run == '0 && !ref_drive_low));

    assert_nolock_R9: assert property (@(posedge clk) disable iff (rst)
        !pll_lock |-> pair_run == '0);
endmodule

bind clkout_pm_ctrl clkpm_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .pwrgd_in       (pwrgd_in),
    .pll_lock       (pll_lock),
    .bus_addr       (bus_addr),
    .ss_mode        (ss_mode),
    .pair_run       (pair_run),
    .pair_drive_low (pair_drive_low),
    .ref_hiz        (ref_hiz),
    .ref_drive_low  (ref_drive_low)
);

// File: tb/sim_clkout_pm_ctrl.sv
`timescale 1ns/1ps
module sim_clkout_pm_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrgd_in = 1'b0;
    logic [1:0] oe_n_in = 2'b00;
    logic       pll_lock = 1'b0;
    logic       strap_addr_sel = 1'b0;
    logic [1:0] strap_ss_lvl = 2'b00;
    logic       oe_wr = 1'b0;
    logic [1:0] oe_wdata = 2'b00;
    logic [6:0] bus_addr;
    logic [1:0] ss_mode;
    logic [1:0] pair_run;
    logic [1:0] pair_drive_low;
    logic       ref_hiz;
    logic       ref_drive_low;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic       m_started;
    logic [1:0] m_oe;

    always #2 clk = ~clk;

    clkout_pm_ctrl u0 (
        .clk(clk), .rst(rst), .pwrgd_in(pwrgd_in), .oe_n_in(oe_n_in),
        .pll_lock(pll_lock), .strap_addr_sel(strap_addr_sel),
        .strap_ss_lvl(strap_ss_lvl), .oe_wr(oe_wr), .oe_wdata(oe_wdata),
        .bus_addr(bus_addr), .ss_mode(ss_mode), .pair_run(pair_run),
        .pair_drive_low(pair_drive_low), .ref_hiz(ref_hiz),
        .ref_drive_low(ref_drive_low)
    );

    function automatic logic [6:0] exp_addr(input logic sel);
        return sel ? 7'b1101010 : 7'b1101000;
    endfunction

    function automatic logic [1:0] exp_ss(input logic [1:0] lvl);
        return (lvl == 2'b01) ? 2'b01 : (lvl == 2'b10) ? 2'b10 : 2'b00;
    endfunction

    function automatic logic [1:0] exp_run(input logic st, input logic pg,
                                           input logic lk, input logic [1:0] oen,
                                           input logic [1:0] reg_bits);
        return (st && pg && lk) ? (~oen & reg_bits) : 2'b00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        m_started = 1'b0;
        m_oe = 2'b11;
    endtask

    task automatic write_oe(input logic [1:0] v);
        oe_wr = 1'b1;
        oe_wdata = v;
        @(negedge clk);
        oe_wr = 1'b0;
        m_oe = v;
    endtask

    task automatic start_up(input logic sel, input logic [1:0] lvl);
        pwrgd_in = 1'b0;
        do_reset();
        chk("R8 hiz before start", ref_hiz, 1);
        strap_addr_sel = sel;
        strap_ss_lvl = lvl;
        pwrgd_in = 1'b1;
        cyc(4);
        m_started = 1'b1;
        chk("R2 address strap", bus_addr, exp_addr(sel));
        chk("R3 spread strap", ss_mode, exp_ss(lvl));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F3A_5C07));
        m_started = 1'b0;
        m_oe = 2'b11;

        // R1 reset state
        do_reset();
        chk("R1 ref_hiz", ref_hiz, 1);
        chk("R1 ref_drive_low", ref_drive_low, 0);
        chk("R1 pair_run", pair_run, 2'b00);
        chk("R1 pair_drive_low", pair_drive_low, 2'b11);
        chk("R1 bus_addr", bus_addr, 7'b1101000);
        chk("R1 ss_mode", ss_mode, 2'b00);

        // R10 latency; capture and gating in the same start-up cycle
        pll_lock = 1'b1;
        oe_n_in = 2'b00;
        strap_addr_sel = 1'b1;
        strap_ss_lvl = 2'b10;
        pwrgd_in = 1'b1;
        cyc(2);
        chk("R10 still hiz after two edges", ref_hiz, 1);
        chk("R10 no run after two edges", pair_run, 2'b00);
        cyc(1);
        chk("R10 hiz falls after third edge", ref_hiz, 0);
        chk("R1 reset enable bits let pairs run", pair_run, 2'b11);
        chk("R6 complement", pair_drive_low, 2'b00);
        chk("R2 addr sel=1", bus_addr, 7'b1101010);
        chk("R3 high level", ss_mode, 2'b10);
        m_started = 1'b1;

        // R4 strap changes and power cycle ignored; R5 and R8 power-down
        strap_addr_sel = 1'b0;
        strap_ss_lvl = 2'b01;
        pwrgd_in = 1'b0;
        cyc(3);
        chk("R5 power-down pairs low", pair_drive_low, 2'b11);
        chk("R8 ref low in power-down", ref_drive_low, 1);
        chk("R8 ref not hiz", ref_hiz, 0);
        chk("R4 addr held in power-down", bus_addr, 7'b1101010);
        pwrgd_in = 1'b1;
        cyc(3);
        chk("R4 addr held after exit", bus_addr, 7'b1101010);
        chk("R4 ss held after exit", ss_mode, 2'b10);
        chk("R8 ref running", ref_drive_low, 0);

        // R9 lock loss
        pll_lock = 1'b0;
        cyc(1);
        chk("R9 unlocked", pair_run, 2'b00);
        pll_lock = 1'b1;
        cyc(1);

        // R7 register writes
        write_oe(2'b01);
        chk("R7 pair1 disabled by register", pair_run, 2'b01);
        write_oe(2'b10);
        chk("R7 pair0 disabled by register", pair_run, 2'b10);
        write_oe(2'b11);

        // R6 pins through synchroniser
        oe_n_in = 2'b10;
        cyc(1);
        chk("R10 pin not yet seen", pair_run, 2'b11);
        cyc(2);
        chk("R6 pin disables pair1", pair_run, 2'b01);

        // Random mix checked against model
        for (int it = 0; it < 80; it++) begin
            logic [1:0] nv;
            pwrgd_in = 1'($urandom());
            pll_lock = 1'($urandom_range(0, 3) != 0);
            oe_n_in = 2'($urandom());
            if ($urandom_range(0, 2) == 0) begin
                nv = 2'($urandom());
                write_oe(nv);
            end
            strap_addr_sel = 1'($urandom());
            strap_ss_lvl = 2'($urandom());
            cyc(4);
            chk("R6 random run", pair_run,
                exp_run(m_started, pwrgd_in, pll_lock, oe_n_in, m_oe));
            chk("R8 random ref low", ref_drive_low, !pwrgd_in);
            chk("R4 random addr hold", bus_addr, 7'b1101010);
        end

        // R2 and R3 across all strap combinations, each after a fresh reset
        pll_lock = 1'b1;
        oe_n_in = 2'b00;
        for (int c = 0; c < 8; c++) begin
            start_up(c[2], c[1:0]);
            chk("R3 never 11", ss_mode == 2'b11, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule